// File: doc/BRIEF.md
# Display Frame Address Generator

This block produces the halfword read addresses that a display fetch engine uses to pull one frame of pixel data out of memory. Memory holds the image row by row in display order: the first row from its leftmost pixel rightwards, then the next row below it. The block issues one address per accepted fetch. After the last halfword of a visible line it adds a programmable skip, so a visible window can sit inside a wider stored image. Once the frame's end address is reached it wraps back to the frame's first halfword and signals the end of the frame.

All addresses are counted in 16-bit halfwords. Bits 20:0 of the output hold the halfword address, which is byte address bits 21:1. Bits 29:21 of the output hold a bank value, which is the byte address bits above bit 21. The counter only ever changes the halfword part. The bank, start, end, line width and skip values are sampled from the configuration inputs when `frame_start_i` is pulsed, and they stay in force across automatic frame wraps until the next pulse.

The end address is exclusive. Software normally sets it to the start address plus rows times the line width in halfwords, with the skips between rows added when the skip is not zero. The address output is a valid/ready stream:
- Once started, `addr_valid_o` stays high.
- The address is consumed only on a cycle where `addr_valid_o` and `addr_ready_i` are both high.
- While `addr_ready_i` is low, the offered address is held unchanged, so the consumer may stall for any number of cycles.

Top module: `frame_addr_gen`

## Requirements
- R1: After reset, `addr_valid_o` and `frame_done_o` are low and stay low until the first `frame_start_i` pulse.
- R2: A `frame_start_i` pulse samples all configuration inputs. In the next cycle `addr_valid_o` is high and `addr_o` equals {bank, start}, with the line position reset to column zero.
- R3: A handshake on a halfword that is not the last of its line makes the next offered address the current halfword address plus one.
- R4: A handshake on the last halfword of a line (column equal to width minus one, where the width is in halfwords and is at least 1) makes the next address the current address plus one plus the skip. A skip of zero gives contiguous lines.
- R5: While `addr_valid_o` is high and `addr_ready_i` is low, `addr_o` and `addr_valid_o` keep their values in the following cycle (back-pressure).
- R6: When the address produced by R3 or R4 would be greater than or equal to the end address, the next offered address is the sampled start address and the column returns to zero.
- R7: `frame_done_o` is high for exactly the one cycle after the handshake that causes the R6 wrap, and is low at all other times.
- R8: Bits 29:21 of `addr_o` always equal the bank sampled at the last frame start. Configuration input changes after a frame start have no effect on the offered addresses, including after automatic wraps, until the next `frame_start_i`.
- R9: A `frame_start_i` pulse during a frame restarts the scan at the newly sampled start address in the next cycle. It takes priority over a handshake in the same cycle, and that handshake produces no `frame_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bank_i | input | 9 | Bank value, byte address bits above 21 |
| cfg_start_i | input | 21 | First halfword address of the frame |
| cfg_end_i | input | 21 | Exclusive end halfword address |
| cfg_width_i | input | 11 | Visible line width in halfwords, at least 1 |
| cfg_skip_i | input | 11 | Halfwords skipped after each line |
| frame_start_i | input | 1 | Pulse: sample configuration and restart |
| addr_valid_o | output | 1 | Address offered |
| addr_ready_i | input | 1 | Consumer accepts the offered address |
| addr_o | output | 30 | {bank, halfword address} |
| frame_done_o | output | 1 | One-cycle pulse after the frame's last fetch |

## Verification
Every result of this block is due exactly one clock after its cause:
- The start address appears one cycle after the `frame_start_i` edge.
- Each advanced, held or wrapped address appears one cycle after the edge that did or did not complete a handshake.
- `frame_done_o` rises in the cycle after the wrapping handshake.

The bench drives inputs and compares outputs on the falling edge. At each falling edge it first checks what the preceding rising edge produced. It then decides whether the coming edge completes a handshake and advances its own model index and its expected done flag to match. The expected address for the k-th fetch of a frame is computed in closed form as start + (k / width) * (width + skip) + k mod width. The frame length is the count of such addresses that fall below the end address.

// File: rtl/fag_pkg.sv
package fag_pkg;

  // what the counters do at the next clock edge
  typedef enum logic [2:0] {
    STEP_HOLD  = 3'd0,
    STEP_LOAD  = 3'd1,
    STEP_NEXT  = 3'd2,
    STEP_LINE  = 3'd3,
    STEP_WRAP  = 3'd4
  } step_e;

endpackage

// File: rtl/fag_cfg_shadow.sv
module fag_cfg_shadow #(
  parameter int BANK_W = 9,
  parameter int HW_W   = 21,
  parameter int LW_W   = 11,
  parameter int SK_W   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [HW_W-1:0]   start_in,
  input  logic [HW_W-1:0]   end_in,
  input  logic [LW_W-1:0]   width_in,
  input  logic [SK_W-1:0]   skip_in,
  output logic [BANK_W-1:0] bank_q,
  output logic [HW_W-1:0]   start_q,
  output logic [HW_W-1:0]   end_q,
  output logic [LW_W-1:0]   width_q,
  output logic [SK_W-1:0]   skip_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q  <= '0;
      start_q <= '0;
      end_q   <= '0;
      width_q <= '0;
      skip_q  <= '0;
    end else if (load) begin
      bank_q  <= bank_in;
      start_q <= start_in;
      end_q   <= end_in;
      width_q <= width_in;
      skip_q  <= skip_in;
    end
  end

  // shadow values move only on a frame start
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(bank_q) && $stable(start_q) && $stable(end_q)
               && $stable(width_q) && $stable(skip_q)));

endmodule

// File: rtl/fag_line_ctr.sv
module fag_line_ctr
  import fag_pkg::*;
#(
  parameter int LW_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  step_e           step,
  input  logic [LW_W-1:0] width,
  output logic            last_col
);

  logic [LW_W-1:0] col_q;

  assign last_col = (col_q == width - LW_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
    end else begin
      unique case (step)
        STEP_LOAD, STEP_WRAP, STEP_LINE: col_q <= '0;
        STEP_NEXT:                       col_q <= col_q + LW_W'(1);
        default:                         col_q <= col_q;
      endcase
    end
  end

  // column never runs past the line width
  p_col_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (width != '0 && col_q < width && step != STEP_LOAD) |=> (col_q < width));

  // a line-end step always returns to column zero
  p_line_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_LINE) |=> (col_q == '0));

endmodule

// File: rtl/fag_hw_ctr.sv
module fag_hw_ctr
  import fag_pkg::*;
#(
  parameter int HW_W = 21,
  parameter int SK_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  step_e           step,
  input  logic [HW_W-1:0] start_new,
  input  logic [HW_W-1:0] start_sh,
  input  logic [HW_W-1:0] end_sh,
  input  logic [SK_W-1:0] skip_sh,
  input  logic            last_col,
  output logic [HW_W-1:0] cur,
  output logic            wrap
);

  localparam int EXT_W = HW_W + 1;

  logic [EXT_W-1:0] cand;
  logic [EXT_W-1:0] skip_ext;

  assign skip_ext = last_col ? EXT_W'(skip_sh) : '0;
  assign cand     = {1'b0, cur} + EXT_W'(1) + skip_ext;
  assign wrap     = (cand >= {1'b0, end_sh});

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else begin
      unique case (step)
        STEP_LOAD:            cur <= start_new;
        STEP_WRAP:            cur <= start_sh;
        STEP_NEXT, STEP_LINE: cur <= cand[HW_W-1:0];
        default:              cur <= cur;
      endcase
    end
  end

  // an in-line advance moves by exactly one halfword
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_NEXT) |=> (cur == $past(cur) + HW_W'(1)));

  // a wrap lands on the sampled start
  p_wrap_start_r6: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_WRAP) |=> (cur == start_sh));

endmodule

// File: rtl/frame_addr_gen.sv
module frame_addr_gen
  import fag_pkg::*;
#(
  parameter int BANK_W = 9,
  parameter int HW_W   = 21,
  parameter int LW_W   = 11,
  parameter int SK_W   = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [BANK_W-1:0]      cfg_bank_i,
  input  logic [HW_W-1:0]        cfg_start_i,
  input  logic [HW_W-1:0]        cfg_end_i,
  input  logic [LW_W-1:0]        cfg_width_i,
  input  logic [SK_W-1:0]        cfg_skip_i,
  input  logic                   frame_start_i,
  output logic                   addr_valid_o,
  input  logic                   addr_ready_i,
  output logic [BANK_W+HW_W-1:0] addr_o,
  output logic                   frame_done_o
);

  localparam int ADDR_W = BANK_W + HW_W;

  logic [BANK_W-1:0] sh_bank;
  logic [HW_W-1:0]   sh_start, sh_end, cur;
  logic [LW_W-1:0]   sh_width;
  logic [SK_W-1:0]   sh_skip;
  logic              active_q, done_q, hs, wrap, last_col;
  step_e             step;

  assign hs = active_q & addr_ready_i;

  always_comb begin
    if (frame_start_i)   step = STEP_LOAD;
    else if (!hs)        step = STEP_HOLD;
    else if (wrap)       step = STEP_WRAP;
    else if (last_col)   step = STEP_LINE;
    else                 step = STEP_NEXT;
  end

  fag_cfg_shadow #(.BANK_W(BANK_W), .HW_W(HW_W), .LW_W(LW_W), .SK_W(SK_W)) u_shadow (
    .clk(clk), .rst(rst), .load(frame_start_i),
    .bank_in(cfg_bank_i), .start_in(cfg_start_i), .end_in(cfg_end_i),
    .width_in(cfg_width_i), .skip_in(cfg_skip_i),
    .bank_q(sh_bank), .start_q(sh_start), .end_q(sh_end),
    .width_q(sh_width), .skip_q(sh_skip)
  );

  fag_line_ctr #(.LW_W(LW_W)) u_line (
    .clk(clk), .rst(rst), .step(step), .width(sh_width), .last_col(last_col)
  );

  fag_hw_ctr #(.HW_W(HW_W), .SK_W(SK_W)) u_hw (
    .clk(clk), .rst(rst), .step(step), .start_new(cfg_start_i),
    .start_sh(sh_start), .end_sh(sh_end), .skip_sh(sh_skip),
    .last_col(last_col), .cur(cur), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (frame_start_i) active_q <= 1'b1;
      done_q <= (step == STEP_WRAP);
    end
  end

  assign addr_valid_o = active_q;
  assign addr_o       = {sh_bank, cur};
  assign frame_done_o = done_q;

  // back-pressure holds the offered address
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (addr_valid_o && !addr_ready_i && !frame_start_i) |=> (addr_valid_o && $stable(addr_o)));

  // start pulse loads the new start and bank
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start_i |=> (addr_valid_o && addr_o == ADDR_W'({$past(cfg_bank_i), $past(cfg_start_i)})));

  // done only follows an accepted fetch
  p_done_cause_r7: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |-> ($past(addr_valid_o && addr_ready_i) && !$past(frame_start_i)));

  // bank bits do not move within a scan
  p_bank_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    (addr_valid_o && !frame_start_i) |=> $stable(addr_o[ADDR_W-1:HW_W]));

  // offered address stays inside the frame window
  p_in_window_r6: assert property (@(posedge clk) disable iff (rst)
    (addr_valid_o && sh_start < sh_end) |-> (cur >= sh_start && cur < sh_end));

  // nothing offered before the first start
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!addr_valid_o && !frame_start_i) |=> (!addr_valid_o && !frame_done_o));

endmodule

// File: tb/frame_addr_gen_test.sv
module frame_addr_gen_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  cfg_bank;
  logic [20:0] cfg_start, cfg_end;
  logic [10:0] cfg_width, cfg_skip;
  logic        frame_start, ready;
  logic        valid, done;
  logic [29:0] addr;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_addr_gen uut (
    .clk(clk), .rst(rst),
    .cfg_bank_i(cfg_bank), .cfg_start_i(cfg_start), .cfg_end_i(cfg_end),
    .cfg_width_i(cfg_width), .cfg_skip_i(cfg_skip),
    .frame_start_i(frame_start), .addr_valid_o(valid), .addr_ready_i(ready),
    .addr_o(addr), .frame_done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_hw(int s, int w, int sk, int k);
    return s + (k / w) * (w + sk) + (k % w);
  endfunction

  // scan one configuration; chg scrambles the inputs after the start
  task automatic run_cfg(int b, int s, int w, int sk, int rows, bit exact, bit chg, int ncyc);
    int e, n, k;
    bit dexp, prev_ready;
    e = exact ? (s + rows * (w + sk) - sk) : (s + rows * w);
    n = 0;
    while (exp_hw(s, w, sk, n) < e) n++;
    cfg_bank = 9'(b); cfg_start = 21'(s); cfg_end = 21'(e);
    cfg_width = 11'(w); cfg_skip = 11'(sk);
    frame_start = 1'b1; ready = 1'b0;
    @(posedge clk); @(negedge clk);
    frame_start = 1'b0;
    k = 0; dexp = 1'b0; prev_ready = 1'b0;
    check("R2 valid after start", 32'(valid), 32'd1);
    for (int c = 0; c < ncyc; c++) begin
      check(prev_ready ? "R3/R4/R6 address" : "R5 held address",
            32'(addr[20:0]), 32'(exp_hw(s, w, sk, k)));
      check("R8 bank bits", 32'(addr[29:21]), 32'(b));
      check("R7 done pulse", 32'(done), 32'(dexp));
      if (chg && c == 0) begin
        cfg_bank = ~cfg_bank; cfg_start = cfg_start + 21'd7;
        cfg_end = cfg_end + 21'd3; cfg_width = cfg_width + 11'd1; cfg_skip = cfg_skip + 11'd2;
      end
      ready = ((c * 7 + w + sk) % 5) != 1;
      prev_ready = ready;
      dexp = 1'b0;
      if (ready) begin
        k++;
        if (k == n) begin k = 0; dexp = 1'b1; end
      end
      @(posedge clk); @(negedge clk);
    end
    ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; frame_start = 1'b0; ready = 1'b0;
    cfg_bank = '0; cfg_start = '0; cfg_end = '0; cfg_width = 11'd1; cfg_skip = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    ready = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); @(negedge clk);
      check("R1 idle valid", 32'(valid), 32'd0);
      check("R1 idle done", 32'(done), 32'd0);
    end
    ready = 1'b0;

    // sweep of widths, skips and row counts
    for (int w = 1; w <= 4; w++)
      for (int sk = 0; sk <= 2; sk++)
        for (int rows = 1; rows <= 3; rows++)
          run_cfg(w * 5 + sk, 100 * w + 13 * sk + rows, w, sk, rows,
                  (rows != 2), (sk == 1), 2 * (rows * w) * 2 + 6);

    // R8: configuration scrambled mid-scan, across several wraps
    run_cfg(9'h1a5, 21'h1ffff0 - 40, 3, 2, 3, 1'b1, 1'b1, 60);

    // R9: restart during a frame together with a handshake
    run_cfg(3, 500, 4, 1, 3, 1'b1, 1'b0, 5);
    cfg_bank = 9'd77; cfg_start = 21'd900; cfg_end = 21'd908;
    cfg_width = 11'd2; cfg_skip = 11'd0;
    frame_start = 1'b1; ready = 1'b1;
    @(posedge clk); @(negedge clk);
    frame_start = 1'b0; ready = 1'b0;
    check("R9 restart address", 32'(addr), 32'({9'd77, 21'd900}));
    check("R9 no done on restart", 32'(done), 32'd0);
    check("R9 valid on restart", 32'(valid), 32'd1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule